// File: doc/BRIEF.md
# External Interrupt Sense Unit

This unit watches a small set of asynchronous interrupt pins (two by default) and decides when each one requests service. Each pin has a 2-bit sense code that selects one of four triggers: low level, any change, falling edge or rising edge. Each pin also has an enable mask bit. In the three edge modes a detected event sets a sticky flag. In low-level mode the pin state itself is the pending condition and nothing is latched. Every pin passes through a synchronizer before it is evaluated.

Pending, enabled sources are gated by a global enable and passed to a fixed-priority arbiter. The arbiter drives a per-source request vector and the vector address of the winning source. Acknowledging the request clears the global enable and consumes the winner's latched flag. A return-from-interrupt pulse sets the global enable again. Software configures the unit through three write strobes: one for sense codes, one for masks and one for write-one-to-clear flag clears. It reads the pending state back on the flag outputs.

Top module: `eirq_top`

## Requirements
- R1: After reset all sense codes are 00, all masks are 0, the global enable is 0, the flags read 0 while the pins sit high, no request is raised, and the vector is 0.
- R2: With sense code 00, a pin's flag reads 1 two rising edges after the pin goes low and 0 two edges after it returns high. The condition is never latched.
- R3: With sense code 01, both a falling and a rising pin transition set the pin's flag, visible on the third rising edge after the pin changes.
- R4: Sense code 10 sets the flag only on a falling transition, and sense code 11 sets it only on a rising transition. The opposite transition leaves the flag unchanged.
- R5: A latched edge flag stays set until a clear write with a 1 in that pin's bit position (bit i clears pin i). A 0 bit in a clear write has no effect.
- R6: Request line i is high only while pin i is pending, mask bit i is 1, and the global enable is 1.
- R7: Pin 0 has priority over pin 1. The vector output is 0x02 when pin 0 wins, 0x04 when pin 1 wins, and 0x00 when no request is raised.
- R8: An acknowledge while a request is raised clears the global enable on the next edge and clears the winning pin's latched edge flag. A low-level source and any non-winning source keep their pending state.
- R9: A return-from-interrupt pulse sets the global enable on the next edge.
- R10: A sense-code write that changes a pin's code suppresses any edge event on that pin in the same cycle. Later edges are detected under the new code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPIN | Asynchronous interrupt pins |
| sense_we | input | 1 | Write strobe for all sense codes |
| sense_wdata | input | 2*NPIN | Sense codes, pin i in bits [2i+1:2i] |
| mask_we | input | 1 | Write strobe for the enable masks |
| mask_wdata | input | NPIN | Enable mask, bit i for pin i |
| clr_we | input | 1 | Write strobe for flag clearing |
| clr_wdata | input | NPIN | Write-one-to-clear pattern, bit i for pin i |
| irq_ack_i | input | 1 | Acknowledge of the current vector |
| reti_i | input | 1 | Return-from-interrupt, sets the global enable |
| irq_req_o | output | NPIN | Per-source request lines |
| irq_any_o | output | 1 | Some request is raised |
| irq_vec_o | output | VEC_W | Vector address of the winning source |
| flag_o | output | NPIN | Pending state readback |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The bench targets several corner cases. The first is a code write that lands in exactly the cycle where a synchronized edge appears. A unit without suppression would latch a phantom flag there. The second is an acknowledge taken while both pins are pending. A wrong design would clear the loser's flag, or fail to clear the winner's flag, so the same vector would fire again. The bench also checks that low-level mode stays unlatched across an acknowledge. It checks that a zero clear bit has no effect and that edges of the wrong polarity are ignored. A design that mixes these up would drop or duplicate interrupts.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'b00,
    SNS_ANY  = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

  // Edge trigger decision from the previous and current synchronized level
  function automatic logic edge_hit(sense_e mode, logic prev, logic cur);
    case (mode)
      SNS_ANY:  return prev ^ cur;
      SNS_FALL: return prev & ~cur;
      SNS_RISE: return ~prev & cur;
      default:  return 1'b0;
    endcase
  endfunction

  function automatic logic is_level(sense_e mode);
    return mode == SNS_LOW;
  endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= {STAGES{RST_VAL}};
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/eirq_sense.sv
module eirq_sense
  import eirq_pkg::*;
#(
  parameter logic RST_VAL = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl,
  input  sense_e mode,
  input  logic   mode_chg,
  input  logic   clr,
  input  logic   ack_hit,
  output logic   edge_evt,
  output logic   level_mode,
  output logic   pending
);
  logic prev_q;
  logic flag_q;
  logic flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign level_mode = is_level(mode);
  assign edge_evt   = edge_hit(mode, prev_q, lvl) & ~mode_chg;

  always_comb begin
    if (level_mode)          flag_d = 1'b0;
    else if (edge_evt)       flag_d = 1'b1;
    else if (clr || ack_hit) flag_d = 1'b0;
    else                     flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign pending = level_mode ? ~lvl : flag_q;
endmodule

// File: rtl/eirq_arb.sv
module eirq_arb #(
  parameter int NPIN     = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 2
) (
  input  logic [NPIN-1:0]  req_in,
  input  logic             gie,
  output logic [NPIN-1:0]  req_out,
  output logic [NPIN-1:0]  grant,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  function automatic logic [VEC_W-1:0] vec_addr(int idx);
    return VEC_W'(VEC_STEP * (idx + 1));
  endfunction

  assign req_out = gie ? req_in : '0;
  assign any     = |req_out;

  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < NPIN; i++) begin
      if (req_out[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    vec = '0;
    for (int i = 0; i < NPIN; i++)
      if (grant[i]) vec = vec_addr(i);
  end
endmodule

// File: rtl/eirq_top.sv
module eirq_top
  import eirq_pkg::*;
#(
  parameter int   NPIN        = 2,
  parameter int   SYNC_STAGES = 2,
  parameter logic IDLE_LVL    = 1'b1,
  parameter int   VEC_W       = 8,
  parameter int   VEC_STEP    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              sense_we,
  input  logic [2*NPIN-1:0] sense_wdata,
  input  logic              mask_we,
  input  logic [NPIN-1:0]   mask_wdata,
  input  logic              clr_we,
  input  logic [NPIN-1:0]   clr_wdata,
  input  logic              irq_ack_i,
  input  logic              reti_i,
  output logic [NPIN-1:0]   irq_req_o,
  output logic              irq_any_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [NPIN-1:0]   flag_o,
  output logic              gie_o
);
  logic [NPIN-1:0] mask_q;
  logic            gie_q;
  logic [NPIN-1:0] lvl_w;
  logic [NPIN-1:0] code_chg_w;
  logic [NPIN-1:0] edge_w;
  logic [NPIN-1:0] lvl_mode_w;
  logic [NPIN-1:0] pend_w;
  logic [NPIN-1:0] grant_w;
  logic            ack_take_w;

  assign ack_take_w = irq_ack_i & irq_any_o;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    sense_e code_q;
    sense_e code_new;

    assign code_new      = sense_e'(sense_wdata[2*i +: 2]);
    assign code_chg_w[i] = sense_we && (code_new != code_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= SNS_LOW;
      else if (sense_we) code_q <= code_new;
    end

    eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   (pin_i[i]),
      .q   (lvl_w[i])
    );

    eirq_sense #(.RST_VAL(IDLE_LVL)) u_sense (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (lvl_w[i]),
      .mode       (code_q),
      .mode_chg   (code_chg_w[i]),
      .clr        (clr_we & clr_wdata[i]),
      .ack_hit    (ack_take_w & grant_w[i]),
      .edge_evt   (edge_w[i]),
      .level_mode (lvl_mode_w[i]),
      .pending    (pend_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gie_q <= 1'b0;
    else if (ack_take_w) gie_q <= 1'b0;
    else if (reti_i)     gie_q <= 1'b1;
  end

  eirq_arb #(.NPIN(NPIN), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_arb (
    .req_in  (pend_w & mask_q),
    .gie     (gie_q),
    .req_out (irq_req_o),
    .grant   (grant_w),
    .any     (irq_any_o),
    .vec     (irq_vec_o)
  );

  assign flag_o = pend_w;
  assign gie_o  = gie_q;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int NPIN     = 2,
  parameter int VEC_W    = 8,
  parameter int VEC_STEP = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPIN-1:0]  irq_req,
  input logic             irq_any,
  input logic [VEC_W-1:0] irq_vec,
  input logic             gie,
  input logic [NPIN-1:0]  mask,
  input logic [NPIN-1:0]  grant,
  input logic [NPIN-1:0]  flag,
  input logic             ack,
  input logic             reti,
  input logic             clr_we,
  input logic [NPIN-1:0]  clr_wdata,
  input logic [NPIN-1:0]  code_chg,
  input logic [NPIN-1:0]  level_mode
);
  // R6
  req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~mask) == '0);
  // R6
  req_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> gie);
  // R7
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R7
  prio_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req[0] |-> (irq_vec == VEC_W'(VEC_STEP)));
  // R8
  ack_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_any) |=> !gie);
  // R9
  reti_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq_any)) |=> gie);

  for (genvar i = 0; i < NPIN; i++) begin : g_flag
    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !level_mode[i] && !code_chg[i] && !(clr_we && clr_wdata[i])
       && !(ack && irq_any && grant[i])) |=> flag[i]);
  end
endmodule

bind eirq_top eirq_chk #(.NPIN(NPIN), .VEC_W(VEC_W), .VEC_STEP(VEC_STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req_o),
  .irq_any    (irq_any_o),
  .irq_vec    (irq_vec_o),
  .gie        (gie_o),
  .mask       (mask_q),
  .grant      (grant_w),
  .flag       (flag_o),
  .ack        (irq_ack_i),
  .reti       (reti_i),
  .clr_we     (clr_we),
  .clr_wdata  (clr_wdata),
  .code_chg   (code_chg_w),
  .level_mode (lvl_mode_w)
);

// File: tb/sim_eirq_top.sv
module sim_eirq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin = 2'b11;
  logic       sense_we = 1'b0;
  logic [3:0] sense_wdata = '0;
  logic       mask_we = 1'b0;
  logic [1:0] mask_wdata = '0;
  logic       clr_we = 1'b0;
  logic [1:0] clr_wdata = '0;
  logic       ack = 1'b0;
  logic       reti = 1'b0;
  logic [1:0] req;
  logic       any;
  logic [7:0] vec;
  logic [1:0] flags;
  logic       gie;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  eirq_top u0 (
    .clk (clk), .rst_n (rst_n), .pin_i (pin),
    .sense_we (sense_we), .sense_wdata (sense_wdata),
    .mask_we (mask_we), .mask_wdata (mask_wdata),
    .clr_we (clr_we), .clr_wdata (clr_wdata),
    .irq_ack_i (ack), .reti_i (reti),
    .irq_req_o (req), .irq_any_o (any), .irq_vec_o (vec),
    .flag_o (flags), .gie_o (gie)
  );

  typedef struct {
    string      tag;
    logic [1:0] flags;
    logic [1:0] req;
    logic       any;
    logic [7:0] vec;
    logic       gie;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  // Expected vector is derived from the winning pin index
  function automatic logic [7:0] want_vec(logic [1:0] r);
    if (r[0]) return 8'h02;
    if (r[1]) return 8'h04;
    return 8'h00;
  endfunction

  task automatic expect_state(string tag, logic [1:0] f, logic [1:0] r, logic g);
    exp_t e;
    e.tag = tag; e.flags = f; e.req = r; e.any = |r; e.vec = want_vec(r); e.gie = g;
    sb.push_back(e);
    -> chk_ev;
    #1;
  endtask

  // Monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (flags !== e.flags || req !== e.req || any !== e.any ||
            vec !== e.vec || gie !== e.gie) begin
          errors++;
          $display("FAIL %s: actual flags=%b req=%b any=%b vec=%h gie=%b expected flags=%b req=%b any=%b vec=%h gie=%b",
                   e.tag, flags, req, any, vec, gie, e.flags, e.req, e.any, e.vec, e.gie);
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_sense(logic [3:0] d);
    sense_we = 1'b1; sense_wdata = d; cyc(1); sense_we = 1'b0;
  endtask
  task automatic wr_mask(logic [1:0] d);
    mask_we = 1'b1; mask_wdata = d; cyc(1); mask_we = 1'b0;
  endtask
  task automatic wr_clr(logic [1:0] d);
    clr_we = 1'b1; clr_wdata = d; cyc(1); clr_we = 1'b0;
  endtask
  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask
  task automatic pulse_reti();
    reti = 1'b1; cyc(1); reti = 1'b0;
  endtask

  task automatic finish_run();
    #1;
    if (sb.size() != 0) begin
      errors += sb.size();
      $display("FAIL scoreboard: actual pending=%0d expected pending=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1..all: actual cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    expect_state("R1 reset state", 2'b00, 2'b00, 1'b0);

    // R2 low-level mode, not latched; R6 masked off
    pin[0] = 1'b0; cyc(2);
    expect_state("R2 level low reads pending (R6 masked)", 2'b01, 2'b00, 1'b0);
    pin[0] = 1'b1; cyc(2);
    expect_state("R2 level release not latched", 2'b00, 2'b00, 1'b0);

    // R4 pin0 rising, pin1 falling
    wr_sense(4'b1011);
    expect_state("R4 codes written, no event", 2'b00, 2'b00, 1'b0);
    pin[0] = 1'b0; cyc(3);
    expect_state("R4 rising mode ignores fall", 2'b00, 2'b00, 1'b0);
    pin[0] = 1'b1; cyc(3);
    expect_state("R4 rising edge latched", 2'b01, 2'b00, 1'b0);
    pin[1] = 1'b0; cyc(3);
    expect_state("R4 falling edge latched", 2'b11, 2'b00, 1'b0);

    wr_mask(2'b11);
    expect_state("R6 masks on, gie off", 2'b11, 2'b00, 1'b0);
    pulse_reti();
    expect_state("R9 reti sets gie, R7 pin0 wins", 2'b11, 2'b11, 1'b1);

    wr_clr(2'b00);
    expect_state("R5 zero clear bits no effect", 2'b11, 2'b11, 1'b1);
    wr_clr(2'b01);
    expect_state("R5 clear pin0, R7 pin1 vector", 2'b10, 2'b10, 1'b1);

    pulse_ack();
    expect_state("R8 ack clears gie and winner flag", 2'b00, 2'b00, 1'b0);
    pulse_reti();
    expect_state("R9 reti with nothing pending, R7 vector 0", 2'b00, 2'b00, 1'b1);

    // R3 any-change on both pins
    wr_sense(4'b0101);
    pin[0] = 1'b0; cyc(3);
    expect_state("R3 any-change falling", 2'b01, 2'b01, 1'b1);
    pulse_ack();
    expect_state("R8 ack clears edge flag", 2'b00, 2'b00, 1'b0);
    pin[0] = 1'b1; cyc(3);
    expect_state("R3 any-change rising, R6 gie off", 2'b01, 2'b00, 1'b0);
    pulse_reti();
    expect_state("R9 reti releases request", 2'b01, 2'b01, 1'b1);
    wr_clr(2'b11);
    expect_state("R5 clear all", 2'b00, 2'b00, 1'b1);

    // R10 code change in the cycle the edge is seen
    pin[1] = 1'b1; cyc(2);
    wr_sense(4'b1101);
    cyc(2);
    expect_state("R10 edge suppressed on code change", 2'b00, 2'b00, 1'b1);
    pin[1] = 1'b0; cyc(3);
    expect_state("R4 new rising code ignores fall", 2'b00, 2'b00, 1'b1);
    pin[1] = 1'b1; cyc(3);
    expect_state("R10 later edge under new code", 2'b10, 2'b10, 1'b1);

    // R8 level source survives ack
    wr_sense(4'b1100);
    expect_state("R2 pin0 level mode idle high", 2'b10, 2'b10, 1'b1);
    pin[0] = 1'b0; cyc(2);
    expect_state("R7 level pin0 wins over pin1", 2'b11, 2'b11, 1'b1);
    pulse_ack();
    expect_state("R8 level and loser keep pending", 2'b11, 2'b00, 1'b0);

    finish_run();
  end
endmodule